// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the software-visible programming interface of a four-channel DMA controller. A host drives an 8-bit port bus with a 4-bit register offset to configure each channel's 16-bit address and transfer-count registers, its mode, its mask bit and its software request, plus a controller-wide command byte. Sixteen-bit registers go through the 8-bit port as two byte accesses, low byte first. A single byte-pointer flip-flop, shared by all channels, chooses the byte.

The decoded configuration (mask, software requests, command bits, per-channel mode fields, base and current address and count) is presented on flat output vectors to a separate transfer engine. The engine returns terminal-count pulses and hardware request levels. The terminal-count pulses are kept as sticky flags. A read of the status offset returns these flags together with the requests and clears the flags.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1 (chan_mask = 4'hF). Software requests, command, modes, all address and count registers, terminal-count flags and the byte pointer are 0.
- R2: Writes to offsets 0..7 select channel offset[2:1]. offset[0]=0 selects the address register and offset[0]=1 selects the count register. The byte pointer picks the byte (0 = bits 7:0, 1 = bits 15:8). The byte goes into both the base and the current register. Every read or write of offsets 0..7 toggles the pointer.
- R3: A write to offset 4'hC clears the byte pointer, so the next data access uses the low byte.
- R4: A read of offsets 0..7 returns the byte of the selected channel's current register that the byte pointer picks.
- R5: A write to offset 4'hA sets the mask bit of channel wdata[1:0] to wdata[2] and leaves the other mask bits unchanged.
- R6: A write to offset 4'hF loads all four mask bits from wdata[3:0] (1 = masked).
- R7: A write to offset 4'hE clears all four mask bits.
- R8: A write to offset 4'hD returns every register to its R1 reset value. This includes setting all mask bits and clearing the byte pointer.
- R9: A write to offset 4'hB stores the mode of channel wdata[1:0]. Transfer type wdata[3:2] appears on xfer_type[2c+1:2c], auto-init wdata[4] on auto_init[c], decrement wdata[5] on addr_down[c], and mode wdata[7:6] on xfer_mode[2c+1:2c].
- R10: A read of offset 4'h8 returns the terminal-count flags in bits 3:0 and (req_in OR sw_req) in bits 7:4, then clears the flags. A tc_in pulse sets the matching sticky flag, and a pulse arriving in the same cycle as the status read survives the clear.
- R11: A write to offset 4'h8 loads the command byte. Bit 2 drives ctrl_disable and bit 4 drives rotate_pri.
- R12: A write to offset 4'h9 sets the software request of channel wdata[1:0] to wdata[2].
- R13: When wr_en and rd_en are both high, only the write takes effect. rdata is 0 unless a read (without write) targets offsets 0..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port write strobe, one cycle per byte |
| rd_en | input | 1 | Port read strobe, one cycle per byte |
| offset | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational in the read cycle |
| tc_in | input | 4 | Terminal-count pulses from the transfer engine |
| req_in | input | 4 | Hardware request levels from the transfer engine |
| chan_mask | output | 4 | Per-channel mask bits |
| sw_req | output | 4 | Per-channel software requests |
| ctrl_disable | output | 1 | Command bit 2, controller disabled |
| rotate_pri | output | 1 | Command bit 4, rotating priority |
| xfer_type | output | 8 | Two bits per channel, transfer type |
| auto_init | output | 4 | Per-channel auto-init enable |
| addr_down | output | 4 | Per-channel address decrement |
| xfer_mode | output | 8 | Two bits per channel, transfer mode |
| base_addr | output | 64 | Base address, 16 bits per channel |
| base_count | output | 64 | Base count, 16 bits per channel |
| cur_addr | output | 64 | Current address, 16 bits per channel |
| cur_count | output | 64 | Current count, 16 bits per channel |

## Verification
The properties assume the host presents a strobe for one cycle per byte and that tc_in is low during reset. Where offset and wdata matter, the properties also assume these inputs are known while a strobe is high. The stimulus changes inputs only at the falling edge, and it drops the strobes and tc_in after every operation. The stimulus draws offsets across all sixteen values, including overlapping read and write strobes. It also draws terminal-count pulses, some of which land in the same cycle as a status read, so every property is exercised inside these limits.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int NCH    = 4;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int CH_W   = $clog2(NCH);
    localparam int MODE_W = 6;

    localparam logic [3:0] OFS_STATUS  = 4'h8;
    localparam logic [3:0] OFS_SWREQ   = 4'h9;
    localparam logic [3:0] OFS_MASK1   = 4'hA;
    localparam logic [3:0] OFS_MODE    = 4'hB;
    localparam logic [3:0] OFS_PTRCLR  = 4'hC;
    localparam logic [3:0] OFS_MCLR    = 4'hD;
    localparam logic [3:0] OFS_MASKCLR = 4'hE;
    localparam logic [3:0] OFS_MASKALL = 4'hF;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic cmd_wr;
        logic stat_rd;
        logic swreq_wr;
        logic mask1_wr;
        logic mode_wr;
        logic ptr_clr;
        logic mclr;
        logic mask_clr;
        logic maskall_wr;
    } dec_t;

    // mode field layout: [5:4] transfer mode, [3] decrement, [2] auto-init, [1:0] type
    typedef struct packed {
        logic                              ptr;
        logic [NCH-1:0]                    mask;
        logic [NCH-1:0]                    swreq;
        logic [NCH-1:0]                    tc;
        logic [BYTE_W-1:0]                 cmd;
        logic [NCH-1:0][MODE_W-1:0]        mode;
        logic [NCH-1:0][REG_W-1:0]         base_addr;
        logic [NCH-1:0][REG_W-1:0]         cur_addr;
        logic [NCH-1:0][REG_W-1:0]         base_cnt;
        logic [NCH-1:0][REG_W-1:0]         cur_cnt;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r      = '0;
        r.mask = '1;
        return r;
    endfunction
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
(
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] offset,
    output dec_t       dec
);
    logic rd_only;

    always_comb begin
        rd_only        = rd_en & ~wr_en;
        dec            = '0;
        dec.data_wr    = wr_en   & ~offset[3];
        dec.data_rd    = rd_only & ~offset[3];
        dec.cmd_wr     = wr_en   & (offset == OFS_STATUS);
        dec.stat_rd    = rd_only & (offset == OFS_STATUS);
        dec.swreq_wr   = wr_en   & (offset == OFS_SWREQ);
        dec.mask1_wr   = wr_en   & (offset == OFS_MASK1);
        dec.mode_wr    = wr_en   & (offset == OFS_MODE);
        dec.ptr_clr    = wr_en   & (offset == OFS_PTRCLR);
        dec.mclr       = wr_en   & (offset == OFS_MCLR);
        dec.mask_clr   = wr_en   & (offset == OFS_MASKCLR);
        dec.maskall_wr = wr_en   & (offset == OFS_MASKALL);
    end
endmodule

// File: rtl/dma_rf_rdmux.sv
module dma_rf_rdmux
    import dma_rf_pkg::*;
(
    input  dec_t                       dec,
    input  logic [CH_W-1:0]            sel_ch,
    input  logic                       sel_cnt,
    input  logic                       ptr,
    input  logic [NCH-1:0][REG_W-1:0]  cur_addr,
    input  logic [NCH-1:0][REG_W-1:0]  cur_cnt,
    input  logic [NCH-1:0]             tc,
    input  logic [NCH-1:0]             req,
    output logic [BYTE_W-1:0]          rdata
);
    logic [REG_W-1:0] word;

    always_comb begin
        word  = sel_cnt ? cur_cnt[sel_ch] : cur_addr[sel_ch];
        rdata = '0;
        if (dec.data_rd) begin
            rdata = ptr ? word[REG_W-1 -: BYTE_W] : word[BYTE_W-1:0];
        end else if (dec.stat_rd) begin
            rdata = {req, tc};
        end
    end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [3:0]             offset,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic [3:0]             tc_in,
    input  logic [3:0]             req_in,
    output logic [3:0]             chan_mask,
    output logic [3:0]             sw_req,
    output logic                   ctrl_disable,
    output logic                   rotate_pri,
    output logic [7:0]             xfer_type,
    output logic [3:0]             auto_init,
    output logic [3:0]             addr_down,
    output logic [7:0]             xfer_mode,
    output logic [63:0]            base_addr,
    output logic [63:0]            base_count,
    output logic [63:0]            cur_addr,
    output logic [63:0]            cur_count
);
    regs_t            st_q;
    regs_t            st_d;
    dec_t             dec;
    logic [CH_W-1:0]  sel_ch;
    logic [CH_W-1:0]  cfg_ch;
    logic             sel_cnt;
    logic             ptr_q;
    logic [NCH-1:0]   tc_q;

    assign sel_ch  = offset[CH_W:1];
    assign sel_cnt = offset[0];
    assign cfg_ch  = wdata[CH_W-1:0];
    assign ptr_q   = st_q.ptr;
    assign tc_q    = st_q.tc;

    dma_rf_decode u_dec (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .offset (offset),
        .dec    (dec)
    );

    dma_rf_rdmux u_rdmux (
        .dec      (dec),
        .sel_ch   (sel_ch),
        .sel_cnt  (sel_cnt),
        .ptr      (st_q.ptr),
        .cur_addr (st_q.cur_addr),
        .cur_cnt  (st_q.cur_cnt),
        .tc       (st_q.tc),
        .req      (req_in | st_q.swreq),
        .rdata    (rdata)
    );

    always_comb begin
        int lo;
        st_d = st_q;
        lo   = st_q.ptr ? BYTE_W : 0;

        // sticky terminal count: clear on status read, new pulses win
        if (dec.stat_rd) st_d.tc = '0;
        st_d.tc = st_d.tc | tc_in;

        if (dec.data_wr) begin
            if (sel_cnt) begin
                st_d.base_cnt[sel_ch][lo +: BYTE_W] = wdata;
                st_d.cur_cnt[sel_ch][lo +: BYTE_W]  = wdata;
            end else begin
                st_d.base_addr[sel_ch][lo +: BYTE_W] = wdata;
                st_d.cur_addr[sel_ch][lo +: BYTE_W]  = wdata;
            end
        end
        if (dec.data_wr || dec.data_rd) st_d.ptr = ~st_q.ptr;
        if (dec.ptr_clr)    st_d.ptr = 1'b0;
        if (dec.cmd_wr)     st_d.cmd = wdata;
        if (dec.swreq_wr)   st_d.swreq[cfg_ch] = wdata[2];
        if (dec.mask1_wr)   st_d.mask[cfg_ch]  = wdata[2];
        if (dec.mask_clr)   st_d.mask = '0;
        if (dec.maskall_wr) st_d.mask = wdata[NCH-1:0];
        if (dec.mode_wr)    st_d.mode[cfg_ch] = wdata[7:2];
        if (dec.mclr)       st_d = regs_reset();
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= regs_reset();
        else        st_q <= st_d;
    end

    assign chan_mask    = st_q.mask;
    assign sw_req       = st_q.swreq;
    assign ctrl_disable = st_q.cmd[2];
    assign rotate_pri   = st_q.cmd[4];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign xfer_type[2*g +: 2]          = st_q.mode[g][1:0];
        assign auto_init[g]                 = st_q.mode[g][2];
        assign addr_down[g]                 = st_q.mode[g][3];
        assign xfer_mode[2*g +: 2]          = st_q.mode[g][5:4];
        assign base_addr[REG_W*g +: REG_W]  = st_q.base_addr[g];
        assign base_count[REG_W*g +: REG_W] = st_q.base_cnt[g];
        assign cur_addr[REG_W*g +: REG_W]   = st_q.cur_addr[g];
        assign cur_count[REG_W*g +: REG_W]  = st_q.cur_cnt[g];
    end
endmodule

// File: rtl/dma_rf_checker.sv
module dma_rf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [3:0] offset,
    input logic [3:0] wdata_lo,
    input logic [3:0] tc_in,
    input logic [3:0] chan_mask,
    input logic       ptr_q,
    input logic [3:0] tc_q
);
    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !offset[3]) |=> (ptr_q != $past(ptr_q)));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hC) |=> !ptr_q);

    assert_mask_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hA) |=> (chan_mask[$past(wdata_lo[1:0])] == $past(wdata_lo[2])));

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hF) |=> (chan_mask == $past(wdata_lo)));

    assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hE) |=> (chan_mask == 4'h0));

    assert_master_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 4'hD) |=> (chan_mask == 4'hF && !ptr_q && tc_q == 4'h0));

    assert_tc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && offset == 4'h8 && tc_in == 4'h0) |=> (tc_q == 4'h0));

    assert_tc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in != 4'h0 && !(wr_en && offset == 4'hD)) |=> ((tc_q & $past(tc_in)) == $past(tc_in)));
endmodule

bind dma_regfile dma_rf_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .offset    (offset),
    .wdata_lo  (wdata[3:0]),
    .tc_in     (tc_in),
    .chan_mask (chan_mask),
    .ptr_q     (ptr_q),
    .tc_q      (tc_q)
);

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  offset = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  tc_in = '0, req_in = '0;
    logic [3:0]  chan_mask, sw_req, auto_init, addr_down;
    logic        ctrl_disable, rotate_pri;
    logic [7:0]  xfer_type, xfer_mode;
    logic [63:0] base_addr, base_count, cur_addr, cur_count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    logic        m_ptr;
    logic [3:0]  m_mask, m_sw, m_tc;
    logic [7:0]  m_cmd;
    logic [5:0]  m_mode [4];
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];

    always #2 clk = ~clk;

    dma_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .offset(offset), .wdata(wdata), .rdata(rdata),
        .tc_in(tc_in), .req_in(req_in),
        .chan_mask(chan_mask), .sw_req(sw_req),
        .ctrl_disable(ctrl_disable), .rotate_pri(rotate_pri),
        .xfer_type(xfer_type), .auto_init(auto_init),
        .addr_down(addr_down), .xfer_mode(xfer_mode),
        .base_addr(base_addr), .base_count(base_count),
        .cur_addr(cur_addr), .cur_count(cur_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = 0; m_mask = 4'hF; m_sw = 0; m_tc = 0; m_cmd = 0;
        for (int i = 0; i < 4; i++) begin
            m_mode[i] = 0; m_addr[i] = 0; m_cnt[i] = 0;
        end
    endtask

    function automatic logic [7:0] exp_rd(logic w, logic r, logic [3:0] o, logic [3:0] rq);
        logic [15:0] v;
        if (!r || w) return 8'h00;
        if (o < 8) begin
            v = o[0] ? m_cnt[o[2:1]] : m_addr[o[2:1]];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (o == 4'h8) return {rq | m_sw, m_tc};
        return 8'h00;
    endfunction

    task automatic model_apply(input logic w, input logic r, input logic [3:0] o,
                               input logic [7:0] d, input logic [3:0] t);
        if (w && o == 4'hD) begin
            model_reset();
            return;
        end
        if (r && !w && o == 4'h8) m_tc = 0;
        m_tc = m_tc | t;
        if (w) begin
            if (o < 8) begin
                if (o[0]) begin
                    if (m_ptr) m_cnt[o[2:1]][15:8] = d; else m_cnt[o[2:1]][7:0] = d;
                end else begin
                    if (m_ptr) m_addr[o[2:1]][15:8] = d; else m_addr[o[2:1]][7:0] = d;
                end
                m_ptr = ~m_ptr;
            end
            case (o)
                4'h8: m_cmd = d;
                4'h9: m_sw[d[1:0]] = d[2];
                4'hA: m_mask[d[1:0]] = d[2];
                4'hB: m_mode[d[1:0]] = d[7:2];
                4'hC: m_ptr = 0;
                4'hE: m_mask = 0;
                4'hF: m_mask = d[3:0];
                default: ;
            endcase
        end else if (r && o < 8) begin
            m_ptr = ~m_ptr;
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [7:0]  et, em;
        logic [3:0]  ea, ed;
        logic [63:0] ba, bc;
        for (int i = 0; i < 4; i++) begin
            et[2*i +: 2] = m_mode[i][1:0];
            ea[i]        = m_mode[i][2];
            ed[i]        = m_mode[i][3];
            em[2*i +: 2] = m_mode[i][5:4];
            ba[16*i +: 16] = m_addr[i];
            bc[16*i +: 16] = m_cnt[i];
        end
        chk(tag, {60'd0, chan_mask}, {60'd0, m_mask});
        chk(tag, {60'd0, sw_req}, {60'd0, m_sw});
        chk(tag, {62'd0, rotate_pri, ctrl_disable}, {62'd0, m_cmd[4], m_cmd[2]});
        chk(tag, {40'd0, xfer_mode, addr_down, auto_init, xfer_type}, {40'd0, em, ed, ea, et});
        chk(tag, base_addr, ba);
        chk(tag, base_count, bc);
        chk(tag, cur_addr, ba);
        chk(tag, cur_count, bc);
    endtask

    function automatic string op_tag(logic w, logic r, logic [3:0] o);
        if (w) begin
            if (o < 8) return "R2";
            case (o)
                4'h8: return "R11";
                4'h9: return "R12";
                4'hA: return "R5";
                4'hB: return "R9";
                4'hC: return "R3";
                4'hD: return "R8";
                4'hE: return "R7";
                default: return "R6";
            endcase
        end
        if (r && o < 8) return "R4";
        if (r && o == 4'h8) return "R10";
        return "R13";
    endfunction

    // called just after a falling edge; leaves just after the next one
    task automatic op(input logic w, input logic r, input logic [3:0] o,
                      input logic [7:0] d, input logic [3:0] t);
        string tg;
        tg = (r && !w) ? op_tag(0, r, o) : "R13";
        wr_en = w; rd_en = r; offset = o; wdata = d; tc_in = t;
        #1;
        chk(tg, {56'd0, rdata}, {56'd0, exp_rd(w, r, o, req_in)});
        @(negedge clk);
        wr_en = 0; rd_en = 0; tc_in = 0;
        model_apply(w, r, o, d, t);
        check_outputs(op_tag(w, r, o));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        process::self().srandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1");
        op(0, 1, 4'h8, 8'h00, 4'h0);                     // R1 status zero, R10
        // R2 / R4: load channel 2 address and count, read back
        op(1, 0, 4'h4, 8'h34, 0); op(1, 0, 4'h4, 8'h12, 0);
        op(1, 0, 4'h5, 8'hCD, 0); op(1, 0, 4'h5, 8'hAB, 0);
        chk("R2", base_addr[47:32], 16'h1234);
        chk("R2", cur_count[47:32], 16'hABCD);
        op(0, 1, 4'h4, 0, 0); op(0, 1, 4'h4, 0, 0);     // R4 low then high
        // R3: pointer cleared mid-sequence
        op(1, 0, 4'h0, 8'h11, 0); op(1, 0, 4'hC, 8'h00, 0);
        op(1, 0, 4'h0, 8'h22, 0);
        chk("R3", base_addr[15:0], 16'h0022);
        // R5, R6, R7 masks
        op(1, 0, 4'hA, 8'h01, 0);                        // clear ch1 mask
        op(1, 0, 4'hF, 8'h05, 0);
        op(1, 0, 4'hE, 8'hFF, 0);
        chk("R7", {60'd0, chan_mask}, 64'd0);
        // R9 mode, R11 command, R12 software request
        op(1, 0, 4'hB, 8'b10_1_1_10_11, 0);
        op(1, 0, 4'h8, 8'h14, 0);
        chk("R11", {62'd0, rotate_pri, ctrl_disable}, 64'd3);
        op(1, 0, 4'h9, 8'h06, 0);
        // R10 sticky tc, clear on read, same-cycle pulse survives
        op(0, 0, 4'h0, 0, 4'h9);
        op(0, 1, 4'h8, 0, 4'h2);
        op(0, 1, 4'h8, 0, 4'h0);
        op(0, 1, 4'h8, 0, 4'h0);
        // R13 write and read together, unused read offsets
        op(1, 1, 4'h8, 8'h00, 0);
        op(0, 1, 4'hB, 0, 0);
        // R8 master clear
        op(1, 0, 4'hD, 8'h00, 4'h3);
        op(0, 1, 4'h8, 0, 0);
        // constrained random traffic
        for (int n = 0; n < 800; n++) begin
            logic w, r;
            logic [3:0] o, t;
            v = 8'($urandom);
            w = ($urandom_range(0, 99) < 55);
            r = w ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 9) < 8);
            o = (w && $urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 7))
                                                 : 4'($urandom);
            if (w && o == 4'hD && $urandom_range(0, 3) != 0) o = 4'hB;
            t = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            if ($urandom_range(0, 15) == 0) req_in = 4'($urandom);
            op(w, r, o, v, t);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule